// File: doc/BRIEF.md
# Eight-Bit Timer with Selectable Count Source

This block is an 8-bit up-counter for a small microcontroller subsystem. Each cycle it may advance by one, depending on a 3-bit source selection. The source can be the system clock, one of four divided versions of that clock, a chosen edge of an external pin, or nothing at all, in which case the counter is stopped. A free-running 10-bit prescaler produces the divided rates. It emits single-cycle enable pulses, so every register in the block runs on the one system clock. The external pin first passes through a two-flop synchroniser and then an edge detector, and it is sampled on the rising system clock edge.

Software reaches the block through a small register bus. It writes the source selection and the overflow interrupt enable, reads or loads the count, and reads or clears the overflow flag. A wrap from 255 to 0 sets the flag. The flag is cleared either by an interrupt acknowledge from the interrupt controller or by software writing a one to it. The interrupt request is raised only when the global enable input, the overflow enable bit and the flag are all set.

The register bus has no valid/ready handshake and applies no back-pressure. A write is accepted on every rising edge where `bus_we` is high and takes effect at that edge. Read data is a combinational function of `bus_addr` and the current state.

Top module: `ticktimer8`

## Requirements
- R1: After reset, the count is 0, the source selection is 0, the overflow enable is 0, the overflow flag is 0 and `irq` is low.
- R2: Source code 0 holds the count unchanged. Source code 1 adds one to the count on every clock edge.
- R3: Codes 2, 3, 4 and 5 advance the count once per 8, 64, 256 and 1024 cycles respectively. The prescaler is 0 after reset and adds one on each edge. A tap fires in a cycle where the low 3, 6, 8 or 10 prescaler bits are all ones, so the first divide-by-8 step lands on the eighth edge after reset.
- R4: Code 7 counts rising edges of `ext_in` and code 6 counts falling edges. The input passes through two synchroniser flops and one edge-history flop. A change driven before clock edge k therefore alters the count at edge k+2.
- R5: The register map is as follows. Address 0 holds the count (read/write). Address 1 holds the source code in bits [2:0] and the overflow enable in bit 3; other bits read 0. Address 2 holds the flag in bit 0; other bits read 0. Address 3 reads 0 and ignores writes.
- R6: A write to address 0 loads `bus_wdata` at that edge and takes priority over an increment in the same cycle. Such a cycle never sets the flag.
- R7: The flag sets at the edge where an increment takes the count from 255 to 0.
- R8: The flag clears on an edge with `irq_ack` high, or on an edge with a write to address 2 where bit 0 is 1. A write with bit 0 at 0 leaves the flag unchanged. If a wrap and a clear fall on the same edge, the wrap wins.
- R9: `irq` is high exactly when `gie`, the overflow enable and the flag are all 1. It is a combinational function of `gie` and the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| ext_in | input | 1 | External count pin (asynchronous) |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Overflow interrupt acknowledge |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 10-bit prescaler and two synchroniser stages. With a 10-bit prescaler, the divide-by-1024 rate completes two full periods in about 2100 cycles, so every tap can be checked cycle by cycle within a short run. With an 8-bit count, a wrap is reached within a few hundred cycles. This puts wrap-versus-clear collisions and load-versus-increment collisions within reach of both directed and random stimulus.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int REG_ADDR_W = 2;
  localparam int SEL_W      = 3;
  localparam int TAP_NUM    = 4;

  localparam logic [REG_ADDR_W-1:0] ADDR_COUNT = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_FLAG  = 2'd2;

  typedef enum logic [SEL_W-1:0] {
    SRC_STOP     = 3'd0,
    SRC_CLK      = 3'd1,
    SRC_DIV8     = 3'd2,
    SRC_DIV64    = 3'd3,
    SRC_DIV256   = 3'd4,
    SRC_DIV1024  = 3'd5,
    SRC_EXT_FALL = 3'd6,
    SRC_EXT_RISE = 3'd7
  } src_sel_e;

  // log2 of each prescaler division, finest tap first
  function automatic int tap_exp(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [TAP_NUM-1:0] tap_tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  for (genvar i = 0; i < TAP_NUM; i++) begin : g_tap
    localparam int EXP = tap_exp(i);
    assign tap_tick[i] = &pre_q[EXP-1:0];
  end

  AST_DIV8_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tap_tick[0] |=> !tap_tick[0]); // R3

  for (genvar j = 1; j < TAP_NUM; j++) begin : g_nest
    AST_TAP_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
      tap_tick[j] |-> tap_tick[j-1]); // R3
  end
endmodule

// File: rtl/tmr8_extsync.sv
module tmr8_extsync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic rise_pulse,
  output logic fall_pulse
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   hist_q;
  logic                   synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      hist_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], ext_in};
      hist_q  <= chain_q[SYNC_STAGES-1];
    end
  end

  assign synced     = chain_q[SYNC_STAGES-1];
  assign rise_pulse = synced & ~hist_q;
  assign fall_pulse = ~synced & hist_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse); // R4

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |=> !fall_pulse); // R4
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  assign wrap = inc && !load && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (load) count <= load_val;
    else if (inc)  count <= count + 1'b1;
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val)); // R6

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && inc) |=> count == CNT_W'($past(count) + 1'b1)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc) |=> $stable(count)); // R2
endmodule

// File: rtl/tmr8_ovf_flag.sv
module tmr8_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R7

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag); // R8

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(flag)); // R8
endmodule

// File: rtl/ticktimer8.sv
module ticktimer8
  import tmr8_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]      bus_wdata,
  output logic [CNT_W-1:0]      bus_rdata,
  input  logic                  ext_in,
  input  logic                  gie,
  input  logic                  irq_ack,
  output logic                  irq
);
  localparam int IE_BIT = SEL_W;

  src_sel_e           sel_q;
  logic               ie_q;
  logic [TAP_NUM-1:0] tap_tick;
  logic               ext_rise, ext_fall;
  logic               tick;
  logic               cnt_load, ctrl_wr, flag_w1c;
  logic [CNT_W-1:0]   count;
  logic               wrap, ovf_flag;

  tmr8_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tap_tick(tap_tick)
  );

  tmr8_extsync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in),
    .rise_pulse(ext_rise), .fall_pulse(ext_fall)
  );

  assign cnt_load = bus_we && (bus_addr == ADDR_COUNT);
  assign ctrl_wr  = bus_we && (bus_addr == ADDR_CTRL);
  assign flag_w1c = bus_we && (bus_addr == ADDR_FLAG) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SRC_STOP;
      ie_q  <= 1'b0;
    end else if (ctrl_wr) begin
      sel_q <= src_sel_e'(bus_wdata[SEL_W-1:0]);
      ie_q  <= bus_wdata[IE_BIT];
    end
  end

  always_comb begin
    case (sel_q)
      SRC_CLK:      tick = 1'b1;
      SRC_DIV8:     tick = tap_tick[0];
      SRC_DIV64:    tick = tap_tick[1];
      SRC_DIV256:   tick = tap_tick[2];
      SRC_DIV1024:  tick = tap_tick[3];
      SRC_EXT_FALL: tick = ext_fall;
      SRC_EXT_RISE: tick = ext_rise;
      default:      tick = 1'b0;
    endcase
  end

  tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(tick), .load(cnt_load),
    .load_val(bus_wdata), .count(count), .wrap(wrap)
  );

  tmr8_ovf_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(wrap),
    .clr(irq_ack || flag_w1c), .flag(ovf_flag)
  );

  assign irq = gie && ie_q && ovf_flag;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_COUNT: bus_rdata = count;
      ADDR_CTRL: begin
        bus_rdata[SEL_W-1:0] = sel_q;
        bus_rdata[IE_BIT]    = ie_q;
      end
      ADDR_FLAG: bus_rdata[0] = ovf_flag;
      default:   bus_rdata = '0;
    endcase
  end

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == SRC_STOP && !cnt_load) |=> $stable(count)); // R2

  AST_LOAD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_load && !ovf_flag) |=> !ovf_flag); // R6
endmodule

// File: tb/ticktimer8_tb_top.sv
`timescale 1ns/1ps
module ticktimer8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ext = 1'b0, gie = 1'b0, ack = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  // reference state, derived from the requirements
  int         m_pre;
  logic       m_s1, m_s2, m_prev;
  logic [7:0] m_cnt;
  logic [2:0] m_sel;
  logic       m_ie, m_flag;

  always #4 clk = ~clk;

  ticktimer8 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .ext_in(ext),
    .gie(gie), .irq_ack(ack), .irq(irq)
  );

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_cnt;
      2'd1:    return {4'b0, m_ie, m_sel};
      2'd2:    return {7'b0, m_flag};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_tick();
    case (m_sel)
      3'd1:    return 1'b1;
      3'd2:    return (m_pre % 8) == 7;
      3'd3:    return (m_pre % 64) == 63;
      3'd4:    return (m_pre % 256) == 255;
      3'd5:    return (m_pre % 1024) == 1023;
      3'd6:    return !m_s2 && m_prev;
      3'd7:    return m_s2 && !m_prev;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic       t, ld, wr_flag;
    logic [7:0] c_n;
    logic       f_n;
    #1;
    chk(tag, rdata, exp_rd(addr));
    chk("R9", {7'b0, irq}, {7'b0, gie & m_ie & m_flag});
    t       = exp_tick();
    ld      = we && addr == 2'd0;
    wr_flag = we && addr == 2'd2 && wdata[0];
    c_n     = ld ? wdata : (t ? m_cnt + 8'd1 : m_cnt);
    f_n     = (!ld && t && m_cnt == 8'hFF) ? 1'b1 : ((ack || wr_flag) ? 1'b0 : m_flag);
    @(posedge clk);
    #1;
    if (we && addr == 2'd1) begin
      m_sel = wdata[2:0];
      m_ie  = wdata[3];
    end
    m_cnt  = c_n;
    m_flag = f_n;
    m_pre  = (m_pre + 1) % 1024;
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = ext;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    we = 1'b1; addr = a; wdata = d;
    step(tag);
    we = 1'b0;
  endtask

  task automatic idle(input int n, input logic [1:0] a, input string tag);
    addr = a;
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D2C3B4A));
    m_pre = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    m_cnt = 0; m_sel = 0; m_ie = 0; m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on every register
    gie = 1'b1;
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      step("R1");
    end

    // R2: stopped source keeps the count
    wr(2'd0, 8'h5A, "R6");
    idle(20, 2'd0, "R2");

    // R2 R7 R9: every-cycle source, wrap sets flag and raises irq
    wr(2'd1, 8'h09, "R5");
    wr(2'd0, 8'hFA, "R6");
    idle(12, 2'd0, "R7");
    idle(2, 2'd2, "R7");
    gie = 1'b0; idle(2, 2'd2, "R9"); gie = 1'b1;

    // R8: writing zero has no effect, ack clears
    wr(2'd1, 8'h08, "R5");
    wr(2'd2, 8'h00, "R8");
    idle(2, 2'd2, "R8");
    ack = 1'b1; step("R8"); ack = 1'b0;
    idle(2, 2'd2, "R8");

    // R8: wrap and ack on the same edge, wrap wins
    wr(2'd1, 8'h09, "R5");
    wr(2'd0, 8'hFE, "R6");
    addr = 2'd2; step("R8");
    ack = 1'b1; step("R8"); ack = 1'b0;
    idle(3, 2'd2, "R8");
    wr(2'd2, 8'h01, "R8");
    idle(2, 2'd2, "R8");

    // R6: load on the cycle that would wrap
    wr(2'd0, 8'hFE, "R6");
    wr(2'd0, 8'hFF, "R6");
    wr(2'd0, 8'h10, "R6");
    idle(3, 2'd2, "R6");
    idle(2, 2'd0, "R6");

    // R3: each prescaled rate
    wr(2'd0, 8'h00, "R6");
    wr(2'd1, 8'h02, "R5"); idle(40, 2'd0, "R3");
    wr(2'd1, 8'h03, "R5"); idle(200, 2'd0, "R3");
    wr(2'd1, 8'h04, "R5"); idle(600, 2'd0, "R3");
    wr(2'd1, 8'h0D, "R5"); idle(2100, 2'd0, "R3");

    // R4: external rising then falling edges
    wr(2'd1, 8'h07, "R5");
    for (int i = 0; i < 30; i++) begin
      if (i % 3 == 0) ext = ~ext;
      addr = 2'd0; step("R4");
    end
    wr(2'd1, 8'h06, "R5");
    for (int i = 0; i < 30; i++) begin
      if (i % 2 == 0) ext = ~ext;
      addr = 2'd0; step("R4");
    end

    // R5: address 3 ignores writes, unused control bits read zero
    wr(2'd3, 8'hFF, "R5");
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      step("R5");
    end
    wr(2'd1, 8'hF1, "R5");
    addr = 2'd1; step("R5");

    // random mix, all requirements against the reference
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r     = $urandom;
      we    = (r[2:0] == 3'd0);
      addr  = r[4:3];
      wdata = r[12:5];
      if (we && addr == 2'd0 && r[13]) wdata = 8'hFF;
      ack   = (r[17:14] == 4'd0);
      gie   = r[18] | r[19];
      if (r[20]) ext = ~ext;
      step("R5");
    end
    we = 1'b0; ack = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule